// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This block brings an integer-mode PLL up and takes it down through three mode lines. The lines are an output enable (bit 0), a bypass-off line (bit 1, where 1 means the PLL is not bypassed) and an active-low reset (bit 2, where 1 means out of reset). It takes single-cycle enable, disable and rate-change requests together with an integer multiplier L, so that the output rate is L times the reference rate. It drives the multiplier and a VCO range select to the PLL. It also drives the fixed integer-mode values M = 0 and N = 1 and, when present, a configuration word and a droop word. These fixed values are written once, before any enable.

All waits are counted in reference clock cycles. In the lock variant, the controller waits on a lock flag and gives up after a timeout. In the fixed variant, it waits a fixed number of cycles instead. The variant is chosen by a parameter. The controller can also start with the mode lines already all high, as a PLL left running by earlier boot code would be. In that case it checks lock once and, if lock is missing, raises a warning, shuts the PLL down and runs the setup.

Top module: `pllseq_ctrl`

## Requirements
- R1: During and after reset, with the boot-on option off, the mode lines read 000 and the enabled, lock-error and warning outputs are 0.
- R2: Within three cycles of reset release, M = 0, N = 1, the configuration and droop outputs carry their parameter values, and setup-done is 1.
- R3: An accepted enable sets the mode lines to 010 on the next cycle. They hold 010 for exactly SETTLE_CYC cycles and then become 110.
- R4: In the lock variant, the mode lines become 111 on the cycle after the lock input is sampled high while they are 110. In the fixed variant, they become 111 exactly LOCK_WAIT_CYC cycles after becoming 110.
- R5: If lock is not seen within LOCK_TMO_CYC cycles of the mode lines becoming 110, the lock-error output is set and stays set until reset, and the output enable (bit 0) stays low.
- R6: A disable request clears all three mode lines together on the next cycle, from any state in which they are nonzero.
- R7: The enabled output is 1 only when the mode lines read 111.
- R8: An enable request is ignored unless the mode lines read 000. After a lock timeout, an enable leaves them at 110.
- R9: A rate request while the mode lines read 000 loads the multiplier on the next cycle and leaves the mode lines at 000. The VCO select is then 1 exactly when L > VCO_MAX_L.
- R10: A rate request while running gives 000 on the next cycle. The new multiplier and VCO select appear one cycle later with the lines still at 000. The full enable sequence (010, then 110, then 111) follows.
- R11: With the boot-on option, the mode lines read 111 in reset. If lock is low at the first cycle after reset, the warning is set, the mode lines go to 000 and setup runs.
- R12: A rate request during the bring-up sequence (mode lines 010 or 110) is ignored; the multiplier keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req_i | input | 1 | Enable request, one cycle |
| dis_req_i | input | 1 | Disable request, one cycle |
| rate_req_i | input | 1 | Rate-change request, one cycle |
| rate_mult_i | input | MULT_W | Requested integer multiplier L |
| lock_i | input | 1 | PLL lock status (lock variant only) |
| pll_mode_o | output | 3 | Mode lines: bit 0 output enable, bit 1 bypass-off, bit 2 reset release |
| pll_mult_o | output | MULT_W | Multiplier L driven to the PLL |
| pll_vco_hi_o | output | 1 | High VCO range select |
| pll_m_o | output | MN_W | Fractional numerator, set to 0 by setup |
| pll_n_o | output | MN_W | Fractional denominator, set to 1 by setup |
| pll_cfg_o | output | CFG_W | Configuration word |
| pll_droop_o | output | CFG_W | Droop control word |
| setup_done_o | output | 1 | One-time setup has run |
| busy_o | output | 1 | A sequence step is in progress |
| enabled_o | output | 1 | PLL fully on (mode lines 111) |
| lock_err_o | output | 1 | Sticky lock timeout flag |
| warn_o | output | 1 | Sticky flag: found on at start without lock |

## Verification
The bring-up sequence is run once for each lock arrival delay, from the first cycle of the lock wait up to the last cycle before timeout, and then with lock never arriving. This separates a correct timeout bound from a bound that is off by one cycle. The multiplier is swept over every value while the PLL is down, which places the VCO threshold exactly between L = 40 and L = 41. Rate requests are also issued while running and during bring-up, to tell a proper restart apart from an ignored request. Separate instances cover the fixed-wait variant and a start with the PLL found on without lock.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

   localparam int OE_BIT   = 0;
   localparam int BYPN_BIT = 1;
   localparam int RSTN_BIT = 2;

   localparam logic [2:0] MODE_OFF    = 3'b000;
   localparam logic [2:0] MODE_SETTLE = 3'b010;
   localparam logic [2:0] MODE_LOCKW  = 3'b110;
   localparam logic [2:0] MODE_ON     = 3'b111;

   typedef enum logic [3:0] {
      ST_INIT,
      ST_SETUP,
      ST_OFF,
      ST_SETTLE,
      ST_LOCKW,
      ST_RUN,
      ST_HALT,
      ST_RESTART,
      ST_RELAUNCH
   } seq_state_e;

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] val_i,
   output logic             zero_o
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pllseq_rate.sv
module pllseq_rate #(
   parameter int MULT_W    = 8,
   parameter int L_INIT    = 10,
   parameter int VCO_MAX_L = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [MULT_W-1:0] val_i,
   output logic [MULT_W-1:0] mult_o,
   output logic              vco_hi_o
);

   localparam logic [MULT_W-1:0] LIM   = MULT_W'(VCO_MAX_L);
   localparam logic [MULT_W-1:0] START = MULT_W'(L_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_o   <= START;
         vco_hi_o <= (START > LIM);
      end else if (wr_i) begin
         mult_o   <= val_i;
         vco_hi_o <= (val_i > LIM);
      end
   end

endmodule

// File: rtl/pllseq_setup.sv
module pllseq_setup #(
   parameter int              MN_W      = 8,
   parameter int              CFG_W     = 16,
   parameter bit              CFG_EN    = 1'b1,
   parameter bit              DROOP_EN  = 1'b1,
   parameter logic [CFG_W-1:0] CFG_VAL   = '0,
   parameter logic [CFG_W-1:0] DROOP_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   output logic [MN_W-1:0]  m_o,
   output logic [MN_W-1:0]  n_o,
   output logic [CFG_W-1:0] cfg_o,
   output logic [CFG_W-1:0] droop_o,
   output logic             done_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_o    <= '0;
         n_o    <= '0;
         done_o <= 1'b0;
      end else if (go_i) begin
         m_o    <= '0;
         n_o    <= MN_W'(1);
         done_o <= 1'b1;
      end
   end

   generate
      if (CFG_EN) begin : g_cfg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cfg_o <= '0;
            else if (go_i) cfg_o <= CFG_VAL;
         end
      end else begin : g_nocfg
         assign cfg_o = '0;
      end

      if (DROOP_EN) begin : g_droop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    droop_o <= '0;
            else if (go_i) droop_o <= DROOP_VAL;
         end
      end else begin : g_nodroop
         assign droop_o = '0;
      end
   endgenerate

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
   import pllseq_pkg::*;
#(
   parameter int               MULT_W        = 8,
   parameter int               MN_W          = 8,
   parameter int               CFG_W         = 16,
   parameter int               L_INIT        = 10,
   parameter int               VCO_MAX_L     = 40,
   parameter int               SETTLE_CYC    = 192,
   parameter int               LOCK_WAIT_CYC = 1152,
   parameter int               LOCK_TMO_CYC  = 1920000,
   parameter bit               HAS_LOCK      = 1'b1,
   parameter bit               BOOT_ON       = 1'b0,
   parameter bit               CFG_EN        = 1'b1,
   parameter bit               DROOP_EN      = 1'b1,
   parameter logic [CFG_W-1:0] CFG_VAL       = '0,
   parameter logic [CFG_W-1:0] DROOP_VAL     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req_i,
   input  logic              dis_req_i,
   input  logic              rate_req_i,
   input  logic [MULT_W-1:0] rate_mult_i,
   input  logic              lock_i,
   output logic [2:0]        pll_mode_o,
   output logic [MULT_W-1:0] pll_mult_o,
   output logic              pll_vco_hi_o,
   output logic [MN_W-1:0]   pll_m_o,
   output logic [MN_W-1:0]   pll_n_o,
   output logic [CFG_W-1:0]  pll_cfg_o,
   output logic [CFG_W-1:0]  pll_droop_o,
   output logic              setup_done_o,
   output logic              busy_o,
   output logic              enabled_o,
   output logic              lock_err_o,
   output logic              warn_o
);

   localparam int MAX_A   = (SETTLE_CYC > LOCK_WAIT_CYC) ? SETTLE_CYC : LOCK_WAIT_CYC;
   localparam int TMR_MAX = (MAX_A > LOCK_TMO_CYC) ? MAX_A : LOCK_TMO_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (LOCK_WAIT_CYC < 1) begin : g_bad_wait
         $error("LOCK_WAIT_CYC must be at least 1");
      end
      if (LOCK_TMO_CYC < 1) begin : g_bad_tmo
         $error("LOCK_TMO_CYC must be at least 1");
      end
      if (MULT_W < 1 || MN_W < 1) begin : g_bad_width
         $error("multiplier and M/N widths must be positive");
      end
   endgenerate

   seq_state_e        state_q;
   logic [2:0]        mode_q;
   logic              pend_en_q;
   logic [MULT_W-1:0] pend_mult_q;
   logic              err_q;
   logic              warn_q;

   logic              lock_ok;
   logic              tmo_on;
   logic [TMR_W-1:0]  wait_val;
   logic              tmr_zero;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              rate_wr;
   logic [MULT_W-1:0] rate_val;
   logic              setup_go;
   logic              go_settle;
   logic              go_lockw;

   // lock-wait variant: flag with timeout, or a fixed count
   generate
      if (HAS_LOCK) begin : g_lock
         assign lock_ok  = lock_i;
         assign tmo_on   = 1'b1;
         assign wait_val = TMR_W'(LOCK_TMO_CYC - 1);
      end else begin : g_fixed
         logic unused_lock;
         assign unused_lock = lock_i;
         assign lock_ok     = 1'b0;
         assign tmo_on      = 1'b0;
         assign wait_val    = TMR_W'(LOCK_WAIT_CYC - 1);
      end
   endgenerate

   always_comb begin
      go_settle = ((state_q == ST_OFF) && !dis_req_i && !rate_req_i && en_req_i &&
                   (mode_q == MODE_OFF) && setup_done_o) ||
                  ((state_q == ST_SETUP) && pend_en_q) ||
                  ((state_q == ST_RELAUNCH) && !dis_req_i);
      go_lockw  = (state_q == ST_SETTLE) && !dis_req_i && tmr_zero;
      tmr_load  = go_settle || go_lockw;
      tmr_val   = go_lockw ? wait_val : TMR_W'(SETTLE_CYC - 1);
      rate_wr   = ((state_q == ST_OFF) && !dis_req_i && rate_req_i) ||
                  (state_q == ST_RESTART);
      rate_val  = (state_q == ST_RESTART) ? pend_mult_q : rate_mult_i;
      setup_go  = (state_q == ST_SETUP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_INIT;
         mode_q      <= BOOT_ON ? MODE_ON : MODE_OFF;
         pend_en_q   <= 1'b0;
         pend_mult_q <= '0;
         err_q       <= 1'b0;
         warn_q      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_INIT: begin
               if (mode_q == MODE_ON) begin
                  if (HAS_LOCK && !lock_ok) begin
                     warn_q  <= 1'b1;
                     mode_q  <= MODE_OFF;
                     state_q <= ST_SETUP;
                  end else begin
                     state_q <= ST_RUN;
                  end
               end else begin
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               pend_en_q <= 1'b0;
               if (pend_en_q) begin
                  mode_q  <= MODE_SETTLE;
                  state_q <= ST_SETTLE;
               end else begin
                  state_q <= ST_OFF;
               end
            end
            ST_OFF: begin
               if (go_settle) begin
                  mode_q  <= MODE_SETTLE;
                  state_q <= ST_SETTLE;
               end else if (!dis_req_i && !rate_req_i && en_req_i &&
                            (mode_q == MODE_OFF) && !setup_done_o) begin
                  pend_en_q <= 1'b1;
                  state_q   <= ST_SETUP;
               end
            end
            ST_SETTLE: begin
               if (dis_req_i) begin
                  mode_q  <= MODE_OFF;
                  state_q <= ST_OFF;
               end else if (go_lockw) begin
                  mode_q  <= MODE_LOCKW;
                  state_q <= ST_LOCKW;
               end
            end
            ST_LOCKW: begin
               if (dis_req_i) begin
                  mode_q  <= MODE_OFF;
                  state_q <= ST_OFF;
               end else if (lock_ok) begin
                  mode_q  <= MODE_ON;
                  state_q <= ST_RUN;
               end else if (tmr_zero) begin
                  if (tmo_on) begin
                     err_q   <= 1'b1;
                     state_q <= ST_HALT;
                  end else begin
                     mode_q  <= MODE_ON;
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (dis_req_i) begin
                  mode_q  <= MODE_OFF;
                  state_q <= ST_OFF;
               end else if (rate_req_i) begin
                  mode_q      <= MODE_OFF;
                  pend_mult_q <= rate_mult_i;
                  state_q     <= ST_RESTART;
               end
            end
            ST_HALT: begin
               if (dis_req_i) begin
                  mode_q  <= MODE_OFF;
                  state_q <= ST_OFF;
               end
            end
            ST_RESTART: begin
               state_q <= ST_RELAUNCH;
            end
            ST_RELAUNCH: begin
               if (dis_req_i) begin
                  state_q <= ST_OFF;
               end else begin
                  mode_q  <= MODE_SETTLE;
                  state_q <= ST_SETTLE;
               end
            end
            default: begin
               mode_q  <= MODE_OFF;
               state_q <= ST_OFF;
            end
         endcase
      end
   end

   pllseq_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   pllseq_rate #(
      .MULT_W    (MULT_W),
      .L_INIT    (L_INIT),
      .VCO_MAX_L (VCO_MAX_L)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (rate_wr),
      .val_i    (rate_val),
      .mult_o   (pll_mult_o),
      .vco_hi_o (pll_vco_hi_o)
   );

   pllseq_setup #(
      .MN_W      (MN_W),
      .CFG_W     (CFG_W),
      .CFG_EN    (CFG_EN),
      .DROOP_EN  (DROOP_EN),
      .CFG_VAL   (CFG_VAL),
      .DROOP_VAL (DROOP_VAL)
   ) u_setup (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (setup_go),
      .m_o     (pll_m_o),
      .n_o     (pll_n_o),
      .cfg_o   (pll_cfg_o),
      .droop_o (pll_droop_o),
      .done_o  (setup_done_o)
   );

   assign pll_mode_o = mode_q;
   assign enabled_o  = (mode_q == MODE_ON);
   assign lock_err_o = err_q;
   assign warn_o     = warn_q;
   assign busy_o     = (state_q == ST_INIT)    || (state_q == ST_SETUP)   ||
                       (state_q == ST_SETTLE)  || (state_q == ST_LOCKW)   ||
                       (state_q == ST_RESTART) || (state_q == ST_RELAUNCH);

   // R3
   rst_after_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_mode_o[RSTN_BIT]) |-> pll_mode_o[BYPN_BIT] && $past(pll_mode_o[BYPN_BIT]));

   // R4
   oe_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_mode_o[OE_BIT] |-> pll_mode_o[BYPN_BIT] && pll_mode_o[RSTN_BIT]);

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err_o |=> lock_err_o);

   // R5
   err_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_err_o) |-> !pll_mode_o[OE_BIT]);

   // R6
   dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_req_i && (pll_mode_o != MODE_OFF) && (state_q != ST_INIT)) |=> (pll_mode_o == MODE_OFF));

   // R8
   halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_HALT) && !dis_req_i) |=> (pll_mode_o == MODE_LOCKW));

   // R9
   mult_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pll_mult_o) |-> (pll_mode_o == MODE_OFF));

endmodule

// File: tb/sim_pllseq_ctrl.sv
module sim_pllseq_ctrl;

   localparam int CLK_P  = 10;
   localparam int S_CYC  = 4;
   localparam int W_CYC  = 6;
   localparam int T_CYC  = 12;
   localparam int VMAX   = 40;
   localparam logic [15:0] CFGV = 16'hA5C3;
   localparam logic [15:0] DRPV = 16'h0F0F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic       en0 = 0, dis0 = 0, rate0 = 0, lock0 = 0;
   logic [7:0] mult0 = 0;
   logic       en1 = 0, dis1 = 0;

   logic [2:0]  mode0, mode1, mode2;
   logic [7:0]  lmul0, lmul1, lmul2;
   logic        vco0, vco1, vco2;
   logic [7:0]  m0, n0, m1, n1, m2, n2;
   logic [15:0] cfg0, drp0, cfg1, drp1, cfg2, drp2;
   logic        sd0, sd1, sd2, bz0, bz1, bz2, on0, on1, on2;
   logic        er0, er1, er2, wr0, wr1, wr2;

   pllseq_ctrl #(.SETTLE_CYC(S_CYC), .LOCK_WAIT_CYC(W_CYC), .LOCK_TMO_CYC(T_CYC),
                 .VCO_MAX_L(VMAX), .HAS_LOCK(1'b1), .BOOT_ON(1'b0),
                 .CFG_VAL(CFGV), .DROOP_VAL(DRPV)) u0 (
      .clk(clk), .rst_n(rst_n), .en_req_i(en0), .dis_req_i(dis0), .rate_req_i(rate0),
      .rate_mult_i(mult0), .lock_i(lock0), .pll_mode_o(mode0), .pll_mult_o(lmul0),
      .pll_vco_hi_o(vco0), .pll_m_o(m0), .pll_n_o(n0), .pll_cfg_o(cfg0),
      .pll_droop_o(drp0), .setup_done_o(sd0), .busy_o(bz0), .enabled_o(on0),
      .lock_err_o(er0), .warn_o(wr0));

   pllseq_ctrl #(.SETTLE_CYC(S_CYC), .LOCK_WAIT_CYC(W_CYC), .LOCK_TMO_CYC(T_CYC),
                 .VCO_MAX_L(VMAX), .HAS_LOCK(1'b0), .BOOT_ON(1'b0),
                 .CFG_VAL(CFGV), .DROOP_VAL(DRPV)) u1 (
      .clk(clk), .rst_n(rst_n), .en_req_i(en1), .dis_req_i(dis1), .rate_req_i(1'b0),
      .rate_mult_i(8'd0), .lock_i(1'b0), .pll_mode_o(mode1), .pll_mult_o(lmul1),
      .pll_vco_hi_o(vco1), .pll_m_o(m1), .pll_n_o(n1), .pll_cfg_o(cfg1),
      .pll_droop_o(drp1), .setup_done_o(sd1), .busy_o(bz1), .enabled_o(on1),
      .lock_err_o(er1), .warn_o(wr1));

   pllseq_ctrl #(.SETTLE_CYC(S_CYC), .LOCK_WAIT_CYC(W_CYC), .LOCK_TMO_CYC(T_CYC),
                 .VCO_MAX_L(VMAX), .HAS_LOCK(1'b1), .BOOT_ON(1'b1),
                 .CFG_VAL(CFGV), .DROOP_VAL(DRPV)) u2 (
      .clk(clk), .rst_n(rst_n), .en_req_i(1'b0), .dis_req_i(1'b0), .rate_req_i(1'b0),
      .rate_mult_i(8'd0), .lock_i(1'b0), .pll_mode_o(mode2), .pll_mult_o(lmul2),
      .pll_vco_hi_o(vco2), .pll_m_o(m2), .pll_n_o(n2), .pll_cfg_o(cfg2),
      .pll_droop_o(drp2), .setup_done_o(sd2), .busy_o(bz2), .enabled_o(on2),
      .lock_err_o(er2), .warn_o(wr2));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // enable u0 and walk through the settle window; ends at 110
   task automatic u0_settle();
      for (int i = 1; i <= S_CYC; i++) begin
         chk("R3 settle", {29'd0, mode0}, 32'h2);
         tick();
      end
      chk("R3 reset release", {29'd0, mode0}, 32'h6);
   endtask

   task automatic u0_enable();
      en0 = 1'b1;
      tick();
      en0 = 1'b0;
      u0_settle();
   endtask

   task automatic u0_disable();
      dis0 = 1'b1;
      lock0 = 1'b0;
      tick();
      dis0 = 1'b0;
      chk("R6 disable", {29'd0, mode0}, 32'h0);
      chk("R7 disabled", {31'd0, on0}, 32'h0);
   endtask

   initial begin
      repeat (3) tick();
      // R1 reset state, R11 boot-on reset value
      chk("R1 mode", {29'd0, mode0}, 32'h0);
      chk("R1 enabled", {31'd0, on0}, 32'h0);
      chk("R1 err", {31'd0, er0}, 32'h0);
      chk("R1 warn", {31'd0, wr0}, 32'h0);
      chk("R11 boot mode", {29'd0, mode2}, 32'h7);
      rst_n = 1'b1;
      repeat (3) tick();
      // R2 one-time setup
      chk("R2 m", {24'd0, m0}, 32'h0);
      chk("R2 n", {24'd0, n0}, 32'h1);
      chk("R2 cfg", {16'd0, cfg0}, {16'd0, CFGV});
      chk("R2 droop", {16'd0, drp0}, {16'd0, DRPV});
      chk("R2 done", {31'd0, sd0}, 32'h1);
      chk("R1 mode after", {29'd0, mode0}, 32'h0);
      // R11 found on without lock
      chk("R11 warn", {31'd0, wr2}, 32'h1);
      chk("R11 mode", {29'd0, mode2}, 32'h0);
      chk("R11 setup", {31'd0, sd2}, 32'h1);
      chk("R11 n", {24'd0, n2}, 32'h1);

      // R9 sweep every multiplier while down
      for (int l = 0; l < 256; l++) begin
         rate0 = 1'b1;
         mult0 = 8'(l);
         tick();
         rate0 = 1'b0;
         chk("R9 mult", {24'd0, lmul0}, l);
         chk("R9 vco", {31'd0, vco0}, (l > VMAX) ? 32'h1 : 32'h0);
         chk("R9 mode", {29'd0, mode0}, 32'h0);
      end
      rate0 = 1'b1;
      mult0 = 8'd30;
      tick();
      rate0 = 1'b0;

      // R4 lock arrives after d cycles of waiting, d = 1..T_CYC
      for (int d = 1; d <= T_CYC; d++) begin
         u0_enable();
         for (int j = 1; j <= d; j++) begin
            if (j == d) lock0 = 1'b1;
            tick();
            if (j < d) chk("R4 waiting", {29'd0, mode0}, 32'h6);
            else begin
               chk("R4 locked", {29'd0, mode0}, 32'h7);
               chk("R7 enabled", {31'd0, on0}, 32'h1);
               chk("R5 no err", {31'd0, er0}, 32'h0);
            end
         end
         u0_disable();
      end

      // R12 rate request during bring-up is ignored
      en0 = 1'b1;
      tick();
      en0 = 1'b0;
      rate0 = 1'b1;
      mult0 = 8'd99;
      tick();
      rate0 = 1'b0;
      chk("R12 mult kept", {24'd0, lmul0}, 32'd30);
      chk("R12 mode", {29'd0, mode0}, 32'h2);
      u0_disable();

      // R10 rate change while running
      u0_enable();
      lock0 = 1'b1;
      tick();
      chk("R10 running", {29'd0, mode0}, 32'h7);
      rate0 = 1'b1;
      mult0 = 8'd50;
      tick();
      rate0 = 1'b0;
      chk("R10 down", {29'd0, mode0}, 32'h0);
      chk("R10 old mult", {24'd0, lmul0}, 32'd30);
      tick();
      chk("R10 still down", {29'd0, mode0}, 32'h0);
      chk("R10 new mult", {24'd0, lmul0}, 32'd50);
      chk("R10 vco hi", {31'd0, vco0}, 32'h1);
      tick();
      u0_settle();
      tick();
      chk("R10 back on", {29'd0, mode0}, 32'h7);
      u0_disable();

      // R5 lock timeout, R8 enable ignored afterwards
      u0_enable();
      for (int j = 1; j <= T_CYC; j++) begin
         tick();
         if (j < T_CYC) chk("R5 before timeout", {31'd0, er0}, 32'h0);
      end
      chk("R5 err set", {31'd0, er0}, 32'h1);
      chk("R5 oe low", {29'd0, mode0}, 32'h6);
      en0 = 1'b1;
      tick();
      en0 = 1'b0;
      chk("R8 enable ignored", {29'd0, mode0}, 32'h6);
      u0_disable();
      chk("R5 sticky", {31'd0, er0}, 32'h1);

      // R4 fixed-wait variant
      en1 = 1'b1;
      tick();
      en1 = 1'b0;
      for (int i = 1; i <= S_CYC; i++) begin
         chk("R3 fixed settle", {29'd0, mode1}, 32'h2);
         tick();
      end
      chk("R3 fixed release", {29'd0, mode1}, 32'h6);
      for (int j = 1; j <= W_CYC; j++) begin
         tick();
         if (j < W_CYC) chk("R4 fixed wait", {29'd0, mode1}, 32'h6);
         else chk("R4 fixed on", {29'd0, mode1}, 32'h7);
      end
      chk("R7 fixed enabled", {31'd0, on1}, 32'h1);
      dis1 = 1'b1;
      tick();
      dis1 = 1'b0;
      chk("R6 fixed disable", {29'd0, mode1}, 32'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule